// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This block runs the refill of one 8-word cache line after a miss. When a miss is accepted, it sends one line request to memory. The request carries the line index, the missed word offset and the fetch order. Memory then returns the 8 words one per valid beat, in the order the request named. In wrapped order, the missed word comes back first and the rest follow, wrapping around the end of the line. In linear order, the words come back from word 0 upward. Each beat is written straight into the cache data array. The beat that carries the missed word is also forwarded to the processor on an early-restart strobe, so the processor can resume before the line is complete.

While the fill runs, per-word presence bits record which words have been written. A processor access to the line being filled stalls only while the word it wants is still missing. The block reports the line as complete in the same cycle it writes the last word. That pulse is the moment the cache may set the line's valid bit. A new miss is refused until the current fill has finished.

Top module: `cwf_fill`

## Requirements
- R1: While idle, an asserted `miss_valid` raises `mem_req` in the same cycle. `mem_req_idx`, `mem_req_off` and `mem_req_wrap` then equal `miss_idx`, `miss_off` and `wrap_mode`.
- R2: With `wrap_mode`=1, memory beat k (counting from 0) is written to word offset (miss_off + k) mod 8.
- R3: With `wrap_mode`=0, memory beat k is written to word offset k.
- R4: `cpu_valid` is high on exactly one beat per fill: the beat whose offset equals the missed offset. `cpu_data` then equals that beat's data. In wrapped mode this is beat 0; in linear mode it is beat miss_off.
- R5: `busy` is high from the cycle after a miss is accepted through the cycle of the eighth beat, and low in the cycle after that beat.
- R6: `miss_valid` while busy is ignored: `mem_req` stays low, and the fill in progress continues unchanged.
- R7: `fill_done` pulses high together with the eighth write only, with `arr_idx` equal to the filled line.
- R8: `acc_stall` is high only when busy, `acc_valid`=1, `acc_idx` equals the line being filled and the word at `acc_off` has not yet been written. It is low once that word has been written, for other lines, and when idle.
- R9: After reset, `busy`, `mem_req`, `arr_we`, `cpu_valid`, `fill_done` and `acc_stall` are low.
- R10: `mem_valid` while idle writes nothing: `arr_we`, `cpu_valid` and `fill_done` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss to be refilled |
| miss_idx | input | IDX_W | Line index of the miss |
| miss_off | input | 3 | Missed word within the line |
| wrap_mode | input | 1 | 1: wrapped critical-first order, 0: linear order |
| mem_req | output | 1 | Line request to memory (one cycle) |
| mem_req_idx | output | IDX_W | Requested line |
| mem_req_off | output | 3 | Missed word offset |
| mem_req_wrap | output | 1 | Requested return order |
| mem_valid | input | 1 | Memory beat valid |
| mem_data | input | DATA_W | Memory beat data |
| cpu_valid | output | 1 | Early-restart strobe |
| cpu_data | output | DATA_W | Missed word to the processor |
| arr_we | output | 1 | Data array word write |
| arr_idx | output | IDX_W | Line being written |
| arr_off | output | 3 | Word being written |
| arr_wdata | output | DATA_W | Word data |
| fill_done | output | 1 | Line complete; valid bit may be set |
| busy | output | 1 | Fill in progress |
| acc_valid | input | 1 | Processor access during fill |
| acc_idx | input | IDX_W | Access line index |
| acc_off | input | 3 | Access word offset |
| acc_stall | output | 1 | Access must wait for its word |

## Verification
The bench sweeps every missed offset in both fetch orders. It inserts idle memory cycles that vary with the beat, so that offsets differing by one bit would land on the wrong word. A design that wrapped by the wrong amount, or ignored the mode, would write words to the wrong offsets or raise the restart strobe on the wrong beat. During idle cycles, the bench raises new misses and stray memory beats. A design that accepted them would re-request memory or corrupt the array. Probes of the filling line at assorted offsets check that stalls clear exactly after each word is written and never before. A design that released early would return stale data, and one that held the stall would hang the processor.

// File: rtl/cwf_fill.sv
module cwf_fill #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [IDX_W-1:0]  miss_idx,
  input  logic [$clog2(WORDS)-1:0] miss_off,
  input  logic              wrap_mode,
  output logic              mem_req,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [$clog2(WORDS)-1:0] mem_req_off,
  output logic              mem_req_wrap,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              cpu_valid,
  output logic [DATA_W-1:0] cpu_data,
  output logic              arr_we,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [$clog2(WORDS)-1:0] arr_off,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              fill_done,
  output logic              busy,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [$clog2(WORDS)-1:0] acc_off,
  output logic              acc_stall
);
  localparam int OFF_W = $clog2(WORDS);

  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] crit_q;
  logic [OFF_W-1:0] cnt_q;
  logic             wrap_q;
  logic [WORDS-1:0] have_q;
  logic [OFF_W-1:0] beat_off;
  logic             last;

  assign mem_req      = miss_valid && !busy;
  assign mem_req_idx  = miss_idx;
  assign mem_req_off  = miss_off;
  assign mem_req_wrap = wrap_mode;

  assign beat_off  = wrap_q ? crit_q + cnt_q : cnt_q;
  assign last      = cnt_q == OFF_W'(WORDS - 1);

  assign arr_we    = busy && mem_valid;
  assign arr_idx   = idx_q;
  assign arr_off   = beat_off;
  assign arr_wdata = mem_data;
  assign fill_done = arr_we && last;
  assign cpu_valid = arr_we && (beat_off == crit_q);
  assign cpu_data  = mem_data;
  assign acc_stall = busy && acc_valid && (acc_idx == idx_q) && !have_q[acc_off];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      crit_q <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      have_q <= '0;
    end else if (mem_req) begin
      busy   <= 1'b1;
      idx_q  <= miss_idx;
      crit_q <= miss_off;
      wrap_q <= wrap_mode;
      cnt_q  <= '0;
      have_q <= '0;
    end else if (arr_we) begin
      have_q[beat_off] <= 1'b1;
      cnt_q            <= cnt_q + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

module cwf_fill_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              cpu_valid,
  input logic [DATA_W-1:0] cpu_data,
  input logic              arr_we,
  input logic [DATA_W-1:0] arr_wdata,
  input logic              fill_done,
  input logic              acc_stall
);
  a_r5_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> busy);
  a_r6_no_req_busy:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> !mem_req);
  a_r4_strobe_data:    assert property (@(posedge clk) disable iff (!rst_n) cpu_valid |-> arr_we && cpu_data == arr_wdata);
  a_r7_done_ends:      assert property (@(posedge clk) disable iff (!rst_n) fill_done |=> !busy);
  a_r10_idle_quiet:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !arr_we && !cpu_valid);
  a_r8_stall_busy:     assert property (@(posedge clk) disable iff (!rst_n) acc_stall |-> busy);
endmodule

bind cwf_fill cwf_fill_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .cpu_valid(cpu_valid), .cpu_data(cpu_data), .arr_we(arr_we),
  .arr_wdata(arr_wdata), .fill_done(fill_done), .acc_stall(acc_stall)
);

// File: tb/tb_cwf_fill.sv
module tb_cwf_fill;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [3:0]  miss_idx = '0;
  logic [2:0]  miss_off = '0;
  logic        wrap_mode = 1'b0;
  logic        mem_req, mem_req_wrap;
  logic [3:0]  mem_req_idx;
  logic [2:0]  mem_req_off;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic        cpu_valid, arr_we, fill_done, busy, acc_stall;
  logic [31:0] cpu_data, arr_wdata;
  logic [3:0]  arr_idx;
  logic [2:0]  arr_off;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic [2:0]  acc_off = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cwf_fill dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_idx(miss_idx),
    .miss_off(miss_off), .wrap_mode(wrap_mode), .mem_req(mem_req),
    .mem_req_idx(mem_req_idx), .mem_req_off(mem_req_off), .mem_req_wrap(mem_req_wrap),
    .mem_valid(mem_valid), .mem_data(mem_data), .cpu_valid(cpu_valid),
    .cpu_data(cpu_data), .arr_we(arr_we), .arr_idx(arr_idx), .arr_off(arr_off),
    .arr_wdata(arr_wdata), .fill_done(fill_done), .busy(busy),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_off(acc_off), .acc_stall(acc_stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int line, input int w);
    return 32'hA500_0000 | (line << 8) | w;
  endfunction

  task automatic do_fill(input int line, input int off, input bit wrap);
    bit [7:0] have = '0;
    @(negedge clk);
    miss_valid = 1'b1; miss_idx = 4'(line); miss_off = 3'(off); wrap_mode = wrap;
    #1;
    chk("R1 req", {31'b0, mem_req}, 1);
    chk("R1 idx", {28'b0, mem_req_idx}, line);
    chk("R1 off", {29'b0, mem_req_off}, off);
    chk("R1 wrap", {31'b0, mem_req_wrap}, {31'b0, wrap});
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    chk("R5 busy set", {31'b0, busy}, 1);
    for (int k = 0; k < 8; k++) begin
      int w = wrap ? (off + k) % 8 : k;
      int p = (k * 3 + off) % 8;
      if ((k + off) % 3 == 0) begin
        @(negedge clk);
        mem_valid = 1'b0;
        miss_valid = 1'b1; miss_idx = 4'(line ^ 5); miss_off = 3'(k);
        acc_valid = 1'b1; acc_idx = 4'(line ^ 1); acc_off = 3'(p);
        #1;
        chk("R6 no req busy", {31'b0, mem_req}, 0);
        chk("R8 other line", {31'b0, acc_stall}, 0);
        chk("R5 busy gap", {31'b0, busy}, 1);
      end
      @(negedge clk);
      miss_valid = 1'b0;
      mem_valid = 1'b1; mem_data = word_of(line, w);
      acc_valid = 1'b1; acc_idx = 4'(line); acc_off = 3'(p);
      #1;
      chk("R2/R3 we", {31'b0, arr_we}, 1);
      chk(wrap ? "R2 off" : "R3 off", {29'b0, arr_off}, w);
      chk("R2/R3 data", arr_wdata, word_of(line, w));
      chk("R7 idx", {28'b0, arr_idx}, line);
      chk("R4 strobe", {31'b0, cpu_valid}, (w == off) ? 1 : 0);
      if (w == off) chk("R4 data", cpu_data, word_of(line, off));
      chk("R7 done", {31'b0, fill_done}, (k == 7) ? 1 : 0);
      chk("R8 stall", {31'b0, acc_stall}, have[p] ? 0 : 1);
      chk("R5 busy", {31'b0, busy}, 1);
      have[w] = 1'b1;
    end
    @(negedge clk);
    mem_valid = 1'b0;
    acc_valid = 1'b1; acc_idx = 4'(line); acc_off = 3'(off);
    #1;
    chk("R5 busy clear", {31'b0, busy}, 0);
    chk("R8 idle", {31'b0, acc_stall}, 0);
    @(negedge clk);
    acc_valid = 1'b0;
    mem_valid = 1'b1; mem_data = 32'hDEAD_BEEF;
    #1;
    chk("R10 no we", {31'b0, arr_we}, 0);
    chk("R10 no strobe", {31'b0, cpu_valid}, 0);
    chk("R10 no done", {31'b0, fill_done}, 0);
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 busy", {31'b0, busy}, 0);
    chk("R9 we", {31'b0, arr_we}, 0);
    chk("R9 strobe", {31'b0, cpu_valid}, 0);
    chk("R9 done", {31'b0, fill_done}, 0);
    chk("R9 stall", {31'b0, acc_stall}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 req", {31'b0, mem_req}, 0);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 8; o++)
        do_fill((o * 5 + m * 3) % 16, o, m[0]);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule